// File: doc/BRIEF.md
# SPI Serial Clock and Strobe Generator

This block derives the serial clock of an SPI master from the reference clock. It also produces the single-cycle strobes that tell the shift logic when to drive a new bit and when to capture the incoming one. The divide ratio comes from two counters in cascade. The first is an even prescaler, whose range runs from 2 up to 254. The second divides by the rate field plus one, which gives a range of 1 to 256. One serial clock period therefore spans prescale × (rate + 1) reference cycles.

Polarity sets the level the serial clock rests at between frames. Phase decides which strobe goes with which edge. With phase 0, capture happens on the leading edge of each clock pulse and the next bit is driven on the trailing edge. With phase 1 the two are swapped. The surrounding controller holds the frame request high for as long as it wants clock edges, and it counts the bits itself.

Top module: `spi_rate_gen`

## Requirements
- R1: While a frame runs, the serial clock changes level once every H reference cycles, where H = (P/2) × (rateSel + 1) and P is the effective prescale.
- R2: The effective prescale P is prescale with bit 0 forced to 0; when that result is 0, P is 2 (so prescale values 0 and 1 both give P = 2, and 7 gives P = 6).
- R3: Every rateSel value from 0 to 255 is honoured; prescale 254 with rateSel 255 gives H = 32512.
- R4: While enable or frameActive is low, sclkOut rests at cpol (one cycle after the condition is seen) and launchOut and sampleOut stay low.
- R5: The first clock edge of a frame appears H+1 cycles after the clock edge that first sees enable and frameActive both high, so it is preceded by a full half period; with cpha = 0, a launch pulse appears 1 cycle after that clock edge.
- R6: With cpha = 0, every odd-numbered edge of a frame (1st, 3rd, ...) carries sampleOut and every even-numbered edge carries launchOut.
- R7: With cpha = 1, odd-numbered edges carry launchOut, even-numbered edges carry sampleOut, and there is no launch pulse at frame start.
- R8: launchOut and sampleOut are one reference cycle wide, never high together, and apart from the cpha = 0 start pulse they are high only in a cycle where sclkOut has just changed.
- R9: Dropping enable clears all divider progress, so a frame restarted afterwards again gets the full R5 timing.
- R10: During reset sclkOut, launchOut and sampleOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; low clears the dividers |
| frameActive | input | 1 | High while the controller wants clock edges |
| prescale | input | 8 | Prescale divisor, even, 2 to 254 (bit 0 ignored) |
| rateSel | input | 8 | Second-stage divisor minus one, 0 to 255 |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edges; 1: sample on trailing edges |
| sclkOut | output | 1 | Serial clock |
| launchOut | output | 1 | One-cycle pulse: drive the next bit |
| sampleOut | output | 1 | One-cycle pulse: capture the incoming bit |

## Verification
The range checks on the divider counters assume that prescale and rateSel do not change while a frame is running. They assume the same of cpol and cpha, and the strobe-to-edge relations depend on that too. The stimulus changes the configuration only on the falling clock edge, and only while frameActive has been low for at least two cycles, so the counters are already at zero. frameActive and enable likewise change only on falling edges, which keeps the start and stop conditions clean, single-cycle events for the properties that look one cycle ahead.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic run;       // enable and frame request both high
    logic start;     // first cycle of run
    logic halfTick;  // a half period has elapsed: toggle the serial clock
  } rate_strobe_t;
endpackage

// File: rtl/rate_ctrl.sv
module rate_ctrl
  import spi_rate_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              frameActive,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rateSel,
  output rate_strobe_t      strobes
);
  localparam int HALF_W = PRE_W - 1;

  logic [HALF_W-1:0] halfLim;
  logic [HALF_W-1:0] preCnt;
  logic [RATE_W-1:0] rateCnt;
  logic              run, runQ, step, preTerm, rateTerm;

  // An even prescale P divides by P/2 per half period; bit 0 is dropped, 0 acts as 2.
  always_comb begin
    halfLim = prescale[PRE_W-1:1];
    if (halfLim == '0) halfLim = HALF_W'(1);
  end

  assign run      = enable & frameActive;
  assign step     = run & runQ;
  assign preTerm  = (preCnt == HALF_W'(halfLim - 1'b1));
  assign rateTerm = (rateCnt == rateSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      preCnt  <= '0;
      rateCnt <= '0;
    end else begin
      runQ <= run;
      if (!step) begin
        preCnt  <= '0;
        rateCnt <= '0;
      end else if (preTerm) begin
        preCnt  <= '0;
        rateCnt <= rateTerm ? '0 : rateCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign strobes.run      = run;
  assign strobes.start    = run & ~runQ;
  assign strobes.halfTick = step & preTerm & rateTerm;

  // R2: first-stage count stays below the effective half prescale
  assert_pre_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    preCnt < halfLim);
  // R3: second-stage count never passes the rate field
  assert_rate_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    rateCnt <= rateSel);
  // R9: dropping enable leaves no divider progress behind
  assert_clear_on_disable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (preCnt == '0) && (rateCnt == '0));
endmodule

// File: rtl/rate_dp.sv
module rate_dp
  import spi_rate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpol,
  input  logic         cpha,
  input  rate_strobe_t strobes,
  output logic         sclkOut,
  output logic         launchOut,
  output logic         sampleOut
);
  logic sclkQ, trailQ, launchQ, sampleQ;
  logic leadEdge, sampleNow, launchNow;

  // trailQ = 0 means the next edge is the leading one of a pulse
  assign leadEdge  = ~trailQ;
  assign sampleNow = strobes.halfTick & (leadEdge ^ cpha);
  assign launchNow = (strobes.halfTick & ~(leadEdge ^ cpha)) | (strobes.start & ~cpha);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      trailQ  <= 1'b0;
      launchQ <= 1'b0;
      sampleQ <= 1'b0;
    end else if (!strobes.run) begin
      sclkQ   <= cpol;
      trailQ  <= 1'b0;
      launchQ <= 1'b0;
      sampleQ <= 1'b0;
    end else begin
      launchQ <= launchNow;
      sampleQ <= sampleNow;
      if (strobes.halfTick) begin
        sclkQ  <= ~sclkQ;
        trailQ <= ~trailQ;
      end
    end
  end

  assign sclkOut   = sclkQ;
  assign launchOut = launchQ;
  assign sampleOut = sampleQ;

  // R4: idle level follows polarity
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |=> sclkOut == $past(cpol));
  // R4: no strobes while idle
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |=> !launchOut && !sampleOut);
  // R8: strobes never together
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({launchOut, sampleOut}));
  // R8: a sample pulse sits on a clock transition
  assert_sample_on_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    sampleOut |-> sclkOut != $past(sclkOut));
  // R8: pulses are one cycle wide
  assert_launch_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    launchOut |=> !launchOut);
  assert_sample_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    sampleOut |=> !sampleOut);
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_rate_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              frameActive,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              cpol,
  input  logic              cpha,
  output logic              sclkOut,
  output logic              launchOut,
  output logic              sampleOut
);
  rate_strobe_t strobes;

  rate_ctrl #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .frameActive(frameActive),
    .prescale(prescale), .rateSel(rateSel), .strobes(strobes)
  );

  rate_dp u_dp (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .strobes(strobes),
    .sclkOut(sclkOut), .launchOut(launchOut), .sampleOut(sampleOut)
  );
endmodule

// File: tb/spi_rate_gen_bench.sv
module spi_rate_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic frameActive = 1'b0;
  logic [7:0] prescale = 8'd2;
  logic [7:0] rateSel = 8'd0;
  logic cpol = 1'b0;
  logic cpha = 1'b0;
  logic sclkOut, launchOut, sampleOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  spi_rate_gen u_spi_rate_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .frameActive(frameActive),
    .prescale(prescale), .rateSel(rateSel), .cpol(cpol), .cpha(cpha),
    .sclkOut(sclkOut), .launchOut(launchOut), .sampleOut(sampleOut)
  );

  // Vectors: prescale, rate, polarity, phase, expected half period (R1/R2)
  localparam int NV = 8;
  localparam int V_PRE [NV]  = '{2, 4, 7, 0, 1, 10, 255, 6};
  localparam int V_RATE[NV]  = '{0, 2, 1, 3, 0, 4, 0, 255};
  localparam int V_POL [NV]  = '{0, 1, 0, 1, 1, 0, 1, 0};
  localparam int V_PHA [NV]  = '{0, 0, 1, 1, 0, 1, 0, 1};
  localparam int V_HALF[NV]  = '{1, 6, 6, 4, 1, 25, 127, 768};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runFrame(input int pre, input int rate, input int pol, input int pha,
                          input int half, input int nEdges);
    int t = 0;
    int edges = 0;
    int badTime = 0;
    int badStrobe = 0;
    int firstOk = 1;
    int lastT = 0;
    logic prev;
    @(negedge clk);
    prescale = 8'(pre); rateSel = 8'(rate); cpol = pol[0]; cpha = pha[0];
    enable = 1'b1; frameActive = 1'b0;
    repeat (2) @(negedge clk);
    // R4: idle level and quiet strobes before the frame
    check(sclkOut == pol[0] && !launchOut && !sampleOut, "R4 idle before frame",
          {sclkOut, launchOut, sampleOut}, pol << 2);
    prev = sclkOut;
    frameActive = 1'b1;
    while (edges < nEdges) begin
      @(negedge clk);
      t++;
      if (sclkOut != prev) begin
        edges++;
        prev = sclkOut;
        lastT = t;
        if (t != 1 + edges * half) badTime++;
        // odd edge = leading; sample on leading iff phase 0 (R6/R7)
        if (sampleOut != ((edges % 2 == 1) != (pha == 1)) ||
            launchOut != ((edges % 2 == 1) == (pha == 1))) badStrobe++;
      end else if (t == 1) begin
        if (launchOut != (pha == 0) || sampleOut) firstOk = 0;
      end else if (launchOut || sampleOut) begin
        badStrobe++;
      end
      if (t > 2 + nEdges * half) begin
        badTime++;
        break;
      end
    end
    check(badTime == 0, "R1 edge spacing", lastT, 1 + nEdges * half);
    if (pha == 0) begin
      check(badStrobe == 0, "R6 phase0 strobe pattern", badStrobe, 0);
      check(firstOk == 1, "R5 start launch pulse", firstOk, 1);
    end else begin
      check(badStrobe == 0, "R7 phase1 strobe pattern", badStrobe, 0);
      check(firstOk == 1, "R7 no start launch", firstOk, 1);
    end
    frameActive = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sclkOut == pol[0] && !launchOut && !sampleOut, "R4 idle after frame",
          {sclkOut, launchOut, sampleOut}, pol << 2);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int t;
    int firstT;
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset values
    check(!sclkOut && !launchOut && !sampleOut, "R10 reset outputs",
          {sclkOut, launchOut, sampleOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(sclkOut == 1'b1, "R4 idle follows polarity after reset", sclkOut, 1);

    for (int i = 0; i < NV; i++)
      runFrame(V_PRE[i], V_RATE[i], V_POL[i], V_PHA[i], V_HALF[i], 4);

    // R9: partial progress, drop enable, restart: full first half period again
    @(negedge clk);
    prescale = 8'd4; rateSel = 8'd2; cpol = 1'b0; cpha = 1'b0;
    enable = 1'b1; frameActive = 1'b1;
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sclkOut == 1'b0 && !launchOut && !sampleOut, "R4 enable low idles",
          {sclkOut, launchOut, sampleOut}, 0);
    enable = 1'b1;
    t = 0; firstT = 0;
    while (firstT == 0 && t < 20) begin
      @(negedge clk);
      t++;
      if (sclkOut != 1'b0) firstT = t;
    end
    check(firstT == 7, "R9 restart first edge", firstT, 7);
    frameActive = 1'b0;

    // R3: slowest setting, two edges
    runFrame(254, 255, 0, 1, 32512, 2);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule